// File: doc/BRIEF.md
# Four-Port GPIO Bank with Masked-Write Window

This block holds the control and status state of four 8-bit general-purpose I/O ports, 32 pins in all. Each port has eight registers: pin enable, output enable, output value, input value, interrupt status, interrupt enable, interrupt level and interrupt clear. A simple single-cycle register bus reaches them. Registers of one kind for the four ports sit at consecutive words.

A second copy of the register window sits 0x800 above the first. A write there changes only the bits chosen by a mask in the upper byte of the write data. Software can therefore set or clear single pins with one store and no read-modify-write. To set bits, write `mask<<8 | mask`. To clear bits, write `mask<<8`.

Each pin's input is resynchronised and compared with its interrupt level. A match latches a status bit. The enabled status bits of all ports are merged onto one bank interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: Address offset bits 6:4 select the register kind: 0 enable, 1 output enable, 2 output value, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt level, 7 interrupt clear. Bits 3:2 select port 0 to 3 (pins 8p+7..8p), and bits 10:7 must be zero. A read returns the register in `bus_rdata[7:0]` with all upper bits zero. Reads through the masked window return the same value as the normal window, and the clear register reads as zero.
- R2: In the normal window (offset bit 11 clear), a write to an enable, output enable, output value, interrupt enable or level register loads `bus_wdata[7:0]`.
- R3: In the masked window (offset bit 11 set), a write to one of those five registers gives `(old & ~wdata[15:8]) | (wdata[7:0] & wdata[15:8])`. A zero mask leaves every register unchanged, and other ports are never touched.
- R4: Writes to the input register or the status register have no effect in either window. A masked-window write to the clear register has no effect.
- R5: `pin_oe` is the AND of enable and output enable for each pin. `pin_out` carries the output value only where `pin_oe` is 1, and is 0 elsewhere.
- R6: Each input passes through two flip-flops. A change on `pin_in` is seen in the input register after two rising clock edges, and not after one.
- R7: A status bit is set on every edge where the synchronised input equals the pin's level bit (1 = high, 0 = low). Once set, it stays set until it is cleared.
- R8: A normal-window write of 1s to the clear register clears those status bits. If the pin still qualifies on that same edge, the bit stays set.
- R9: `irq` is 1 exactly when some pin of any port has both its status bit and its interrupt-enable bit set.
- R10: Reset (`rst_n` low, asynchronous) sets all registers and synchronisers to 0. This gives `irq`, `pin_oe` and `pin_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte offset; bit 11 selects the masked window |
| bus_wdata | input | 32 | Write data; [15:8] mask, [7:0] value |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin inputs, port p on bits 8p+7..8p |
| pin_out | output | 32 | Gated output values |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined bank interrupt |

## Verification
On every cycle, the checker confirms the following:
- No pin drives without its drive enable.
- The synchronised inputs equal `pin_in` from two edges earlier.
- A latched status bit is lost only to a clear aimed at it.
- Every qualifying pin has its status set on the next edge.
- A masked write with an empty mask leaves all writable registers unchanged.

Only the bench scenarios can show the following:
- The merge arithmetic of the masked window on real bit patterns.
- Port isolation, and the ignored writes to the input, status and masked-clear registers.
- The one-edge versus two-edge input latency.
- Interrupt masking across ports, and the reset values read back over the bus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register kind codes; the code is the address field at bits 6:4.
  typedef enum logic [2:0] {
    K_EN   = 3'd0,
    K_OE   = 3'd1,
    K_OUT  = 3'd2,
    K_IN   = 3'd3,
    K_STAT = 3'd4,
    K_IEN  = 3'd5,
    K_LEV  = 3'd6,
    K_CLR  = 3'd7
  } reg_kind_e;

  localparam int unsigned KIND_LSB = 4;
  localparam int unsigned KIND_W   = 3;
  localparam int unsigned PORT_LSB = 2;
  localparam int unsigned SPAN_HI  = KIND_LSB + KIND_W; // first bit that must be zero

  // Kind field of a byte offset.
  function automatic reg_kind_e kind_of(input logic [SPAN_HI-1:0] low_addr);
    return reg_kind_e'(low_addr[KIND_LSB +: KIND_W]);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           wr,
  input  logic           use_mask,
  input  reg_kind_e      kind,
  input  logic [2*W-1:0] wd,
  input  logic [W-1:0]   pin_sync,
  output logic [W-1:0]   en_q,
  output logic [W-1:0]   oe_q,
  output logic [W-1:0]   out_q,
  output logic [W-1:0]   ien_q,
  output logic [W-1:0]   lev_q,
  output logic [W-1:0]   stat_q,
  output logic [W-1:0]   qual,
  output logic [W-1:0]   clr_bits
);

  // Keep old bits where the mask is 0, take the value where it is 1.
  function automatic logic [W-1:0] masked_merge(input logic [W-1:0] cur,
                                                input logic [W-1:0] msk,
                                                input logic [W-1:0] val);
    return (cur & ~msk) | (val & msk);
  endfunction

  // Next register value for a write through either window.
  function automatic logic [W-1:0] field_next(input logic [W-1:0]   cur,
                                              input logic           masked,
                                              input logic [2*W-1:0] d);
    return masked ? masked_merge(cur, d[2*W-1:W], d[W-1:0]) : d[W-1:0];
  endfunction

  // A pin qualifies when its synchronised level equals its level bit.
  function automatic logic [W-1:0] level_match(input logic [W-1:0] lvl,
                                               input logic [W-1:0] pins);
    return ~(lvl ^ pins);
  endfunction

  logic wr_here;
  logic hit_en, hit_oe, hit_out, hit_ien, hit_lev, hit_clr;

  assign wr_here = sel && wr;
  assign hit_en  = wr_here && (kind == K_EN);
  assign hit_oe  = wr_here && (kind == K_OE);
  assign hit_out = wr_here && (kind == K_OUT);
  assign hit_ien = wr_here && (kind == K_IEN);
  assign hit_lev = wr_here && (kind == K_LEV);
  assign hit_clr = wr_here && (kind == K_CLR) && !use_mask;

  assign clr_bits = hit_clr ? wd[W-1:0] : '0;
  assign qual     = level_match(lev_q, pin_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      oe_q  <= '0;
      out_q <= '0;
      ien_q <= '0;
      lev_q <= '0;
    end else begin
      if (hit_en)  en_q  <= field_next(en_q,  use_mask, wd);
      if (hit_oe)  oe_q  <= field_next(oe_q,  use_mask, wd);
      if (hit_out) out_q <= field_next(out_q, use_mask, wd);
      if (hit_ien) ien_q <= field_next(ien_q, use_mask, wd);
      if (hit_lev) lev_q <= field_next(lev_q, use_mask, wd);
    end
  end

  // Status: clear first, then a qualifying level sets the bit again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_bits) | qual;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORTS     = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ALIAS_BIT = 11,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [PORTS*PORT_W-1:0] pin_in,
  output logic [PORTS*PORT_W-1:0] pin_out,
  output logic [PORTS*PORT_W-1:0] pin_oe,
  output logic                    irq
);

  localparam int unsigned PIN_W  = PORTS * PORT_W;
  localparam int unsigned PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int unsigned WD_W   = 2 * PORT_W;

  // Address decode
  logic              use_mask;
  logic              in_window;
  reg_kind_e         kind;
  logic [PSEL_W-1:0] psel;

  assign use_mask  = bus_addr[ALIAS_BIT];
  assign in_window = (bus_addr[ALIAS_BIT-1:SPAN_HI] == '0);
  assign kind      = kind_of(bus_addr[SPAN_HI-1:0]);
  assign psel      = bus_addr[PORT_LSB +: PSEL_W];

  // Synchronised inputs
  logic [PIN_W-1:0] sync_all;

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_raw  (pin_in),
    .d_sync (sync_all)
  );

  // Per-port register slices
  logic [PORT_W-1:0] en_a   [PORTS];
  logic [PORT_W-1:0] oe_a   [PORTS];
  logic [PORT_W-1:0] out_a  [PORTS];
  logic [PORT_W-1:0] ien_a  [PORTS];
  logic [PORT_W-1:0] lev_a  [PORTS];
  logic [PORT_W-1:0] stat_a [PORTS];
  logic [PORT_W-1:0] in_a   [PORTS];

  // Flattened views, named for the checker
  logic [PIN_W-1:0] en_all, oe_all, out_all, ien_all, lev_all;
  logic [PIN_W-1:0] stat_all, qual_all, clr_all;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic sel_p;
    assign sel_p = in_window && (psel == PSEL_W'(p));
    assign in_a[p] = sync_all[p*PORT_W +: PORT_W];

    gpio_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel_p),
      .wr       (bus_we),
      .use_mask (use_mask),
      .kind     (kind),
      .wd       (bus_wdata[WD_W-1:0]),
      .pin_sync (in_a[p]),
      .en_q     (en_a[p]),
      .oe_q     (oe_a[p]),
      .out_q    (out_a[p]),
      .ien_q    (ien_a[p]),
      .lev_q    (lev_a[p]),
      .stat_q   (stat_a[p]),
      .qual     (qual_all[p*PORT_W +: PORT_W]),
      .clr_bits (clr_all[p*PORT_W +: PORT_W])
    );

    assign en_all  [p*PORT_W +: PORT_W] = en_a[p];
    assign oe_all  [p*PORT_W +: PORT_W] = oe_a[p];
    assign out_all [p*PORT_W +: PORT_W] = out_a[p];
    assign ien_all [p*PORT_W +: PORT_W] = ien_a[p];
    assign lev_all [p*PORT_W +: PORT_W] = lev_a[p];
    assign stat_all[p*PORT_W +: PORT_W] = stat_a[p];
  end

  // Pin drive
  assign pin_oe  = en_all & oe_all;
  assign pin_out = out_all & pin_oe;

  // Bank interrupt
  assign irq = |(stat_all & ien_all);

  // Read mux
  logic [PORT_W-1:0] rd_field;

  always_comb begin
    rd_field = '0;
    unique case (kind)
      K_EN:    rd_field = en_a[psel];
      K_OE:    rd_field = oe_a[psel];
      K_OUT:   rd_field = out_a[psel];
      K_IN:    rd_field = in_a[psel];
      K_STAT:  rd_field = stat_a[psel];
      K_IEN:   rd_field = ien_a[psel];
      K_LEV:   rd_field = lev_a[psel];
      K_CLR:   rd_field = '0;
      default: rd_field = '0;
    endcase
  end

  assign bus_rdata = in_window ? DATA_W'(rd_field) : '0;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:WD_W], bus_addr[PORT_LSB-1:0],
                         bus_addr[ADDR_W-1:ALIAS_BIT]};

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned PIN_W  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe,
  input logic [PIN_W-1:0]  sync_all,
  input logic [PIN_W-1:0]  stat_all,
  input logic [PIN_W-1:0]  qual_all,
  input logic [PIN_W-1:0]  clr_all,
  input logic [PIN_W-1:0]  en_all,
  input logic [PIN_W-1:0]  oe_all,
  input logic [PIN_W-1:0]  out_all,
  input logic [PIN_W-1:0]  ien_all,
  input logic [PIN_W-1:0]  lev_all
);

  // Edges seen since reset, saturating, to gate the look-back check.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic empty_mask_wr;
  assign empty_mask_wr = bus_we && bus_addr[ADDR_W-1] &&
                         (bus_wdata[2*PORT_W-1:PORT_W] == '0);

  logic unused_chk;
  assign unused_chk = ^{bus_wdata[DATA_W-1:2*PORT_W], bus_wdata[PORT_W-1:0],
                        bus_addr[ADDR_W-2:0]};

  assert_gated_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (sync_all == $past(pin_in, 2)));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |->
      ((($past(stat_all) & ~$past(clr_all)) & ~stat_all) == '0));

  assert_status_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> (($past(qual_all) & ~stat_all) == '0));

  assert_mask_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_mask_wr |=> ($stable(en_all) && $stable(oe_all) && $stable(out_all) &&
                       $stable(ien_all) && $stable(lev_all)));

endmodule

bind gpio_bank gpio_bank_chk #(
  .PIN_W  (PIN_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PORT_W (PORT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .sync_all  (sync_all),
  .stat_all  (stat_all),
  .qual_all  (qual_all),
  .clr_all   (clr_all),
  .en_all    (en_all),
  .oe_all    (oe_all),
  .out_all   (out_all),
  .ien_all   (ien_all),
  .lev_all   (lev_all)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write, offset, data, expected read byte}
  localparam int NV = 26;
  localparam logic [36:0] VECS [NV] = '{
    {1'b1, 12'h020, 16'h00A5, 8'h00},
    {1'b0, 12'h020, 16'h0000, 8'hA5},
    {1'b1, 12'h820, 16'h0F0F, 8'h00},
    {1'b0, 12'h020, 16'h0000, 8'hAF},
    {1'b1, 12'h820, 16'h8000, 8'h00},
    {1'b0, 12'h020, 16'h0000, 8'h2F},
    {1'b1, 12'h824, 16'hFF3C, 8'h00},
    {1'b0, 12'h024, 16'h0000, 8'h3C},
    {1'b0, 12'h020, 16'h0000, 8'h2F},
    {1'b1, 12'h00C, 16'h0011, 8'h00},
    {1'b1, 12'h81C, 16'h0303, 8'h00},
    {1'b0, 12'h01C, 16'h0000, 8'h03},
    {1'b0, 12'h00C, 16'h0000, 8'h11},
    {1'b1, 12'h85C, 16'h00FF, 8'h00},
    {1'b0, 12'h05C, 16'h0000, 8'h00},
    {1'b1, 12'h030, 16'h00FF, 8'h00},
    {1'b0, 12'h030, 16'h0000, 8'h00},
    {1'b1, 12'h830, 16'hFFFF, 8'h00},
    {1'b0, 12'h030, 16'h0000, 8'h00},
    {1'b1, 12'h068, 16'h00F0, 8'h00},
    {1'b1, 12'h868, 16'h0101, 8'h00},
    {1'b0, 12'h068, 16'h0000, 8'hF1},
    {1'b0, 12'h078, 16'h0000, 8'h00},
    {1'b1, 12'h02C, 16'h00FF, 8'h00},
    {1'b0, 12'h02C, 16'h0000, 8'hFF},
    {1'b0, 12'h868, 16'h0000, 8'hF1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = {16'h0000, d};
    bus_we    = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    rd(12'h020, v);
    check("R10 out reg after reset", v, 32'h0);
    check("R10 pin_oe after reset", pin_oe, 32'h0);
    check("R10 pin_out after reset", pin_out, 32'h0);
    check("R10 irq after reset", {31'b0, irq}, 32'h0);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][36]) wr(VECS[i][35:24], VECS[i][23:8]);
      else begin
        rd(VECS[i][35:24], v);
        check($sformatf("R1/R2/R3/R4 vector %0d", i), v, {24'h0, VECS[i][7:0]});
      end
    end

    // R5: port D en=11 oe=03 out=FF; port A out=2F but not enabled
    @(negedge clk);
    check("R5 pin_oe", pin_oe, 32'h0100_0000);
    check("R5 pin_out", pin_out, 32'h0100_0000);

    // R6: two-edge input latency on port B
    @(negedge clk) pin_in[15:8] = 8'h5A;
    @(posedge clk);
    @(negedge clk) bus_addr = 12'h034;
    #1 check("R6 input after one edge", bus_rdata, 32'h00);
    @(posedge clk);
    @(negedge clk);
    #1 check("R6 input after two edges", bus_rdata, 32'h5A);

    // R7 R8: port B level high, clear all; high pins keep their status
    wr(12'h064, 16'h00FF);
    repeat (4) @(posedge clk);
    wr(12'h074, 16'h00FF);
    rd(12'h044, v);
    check("R8 clear with live level", v, 32'h5A);
    check("R9 no enables no irq", {31'b0, irq}, 32'h0);

    wr(12'h854, 16'h0202);
    @(negedge clk);
    check("R9 irq after enable", {31'b0, irq}, 32'h1);

    wr(12'h074, 16'h0002);
    rd(12'h044, v);
    check("R8 set wins over clear", v, 32'h5A);

    @(negedge clk) pin_in[15:8] = 8'h58;
    repeat (5) @(posedge clk);
    rd(12'h044, v);
    check("R7 status latched after level gone", v, 32'h5A);
    check("R9 irq held by latch", {31'b0, irq}, 32'h1);

    wr(12'h878, 16'h0202);
    rd(12'h044, v);
    check("R4 masked clear ignored", v, 32'h5A);
    wr(12'h044, 16'h0000);
    rd(12'h044, v);
    check("R4 status write ignored", v, 32'h5A);

    wr(12'h074, 16'h0002);
    rd(12'h044, v);
    check("R8 clear without level", v, 32'h58);
    check("R9 irq drops", {31'b0, irq}, 32'h0);

    // R9 another port feeds the same line (port A pins low, level low)
    wr(12'h050, 16'h0001);
    @(negedge clk);
    check("R9 irq from port A", {31'b0, irq}, 32'h1);

    // R10 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(12'h02C, v);
    check("R10 out reg after second reset", v, 32'h0);
    check("R10 irq after second reset", {31'b0, irq}, 32'h0);
    check("R10 pin_oe after second reset", pin_oe, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule